// File: doc/BRIEF.md
# Card Bus Clock Generator with Idle Slowdown and FIFO Hold

This block derives the serial card bus clock from the system clock with a programmable divider. While the bus is idle it can slow the card clock further by a power-of-two factor to save power. During a data transfer it can hold the card clock low when the data FIFO cannot take another read word or has no write word ready. This trades bandwidth for data integrity.

Beside the card clock, the block gives a one-cycle shift strobe at every falling edge of the card clock. The command and data serializers use it to advance. No strobe is issued while the clock is held. The FIFO and the transfer engines live outside this block and only supply their status flags.

Top module: `cardclk_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is 0, `card_clk` and `shift_en` are both 0.
- R2: With slowdown inactive, each high level and each low level of `card_clk` lasts `div_sel`+1 system clock cycles, so one period is 2*(`div_sel`+1) cycles.
- R3: When `psave_en`=1 and `bus_busy`=0, each level lasts (`div_sel`+1)*2^(`psave_exp`+1) cycles, including `psave_exp`=0 (factor 2) and `psave_exp`=7 (factor 256). With `bus_busy`=1 the base length from R2 applies.
- R4: With `rd_hold_en`=1, `bus_busy`=1, `xfer_read`=1 (1 means card-to-host) and `fifo_full`=1, `card_clk` stays low and does not rise.
- R5: With `wr_hold_en`=1, `bus_busy`=1, `xfer_read`=0 (host-to-card) and `fifo_empty`=1, `card_clk` stays low. `fifo_empty` does not hold the clock during a read, and `fifo_full` does not hold it during a write.
- R6: A hold never cuts a high level short. If a hold is raised while `card_clk` is high, that level still lasts its full length. After the hold is released, the clock rises at the next level boundary, within one level length, and the following high level has full length.
- R7: `shift_en` is high for exactly one cycle per period: the first cycle in which `card_clk` is low after being high. It stays 0 while the clock is held.
- R8: With `rd_hold_en`=0 and `wr_hold_en`=0, the FIFO flags have no effect and the clock runs at the length given by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Clock generator on |
| div_sel | input | 8 | Divider value; level length is div_sel+1 cycles |
| psave_en | input | 1 | Enable idle slowdown |
| psave_exp | input | 3 | Idle slowdown exponent; factor 2^(psave_exp+1) |
| rd_hold_en | input | 1 | Hold clock on full FIFO during reads |
| wr_hold_en | input | 1 | Hold clock on empty FIFO during writes |
| bus_busy | input | 1 | A transfer is in progress |
| xfer_read | input | 1 | Direction: 1 card-to-host, 0 host-to-card |
| fifo_full | input | 1 | FIFO cannot accept more data |
| fifo_empty | input | 1 | FIFO has no data to send |
| card_clk | output | 1 | Card bus clock |
| shift_en | output | 1 | One-cycle strobe at each card clock falling edge |

## Verification
The assertions assume that every input is synchronous to `clk`, and that the hold condition is judged from the flags in the same cycle as the boundary. They therefore check that the clock stays low in the cycle after a hold is seen. They do not check a delayed reaction. The stimulus changes inputs only at falling edges of the system clock. It keeps the divider and the slowdown settings constant while level lengths are being measured, and it lets two rising edges pass after each change so that a half-finished level is never counted.

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             psave_en,
  input  logic [EXP_W-1:0] psave_exp,
  input  logic             rd_hold_en,
  input  logic             wr_hold_en,
  input  logic             bus_busy,
  input  logic             xfer_read,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output logic             card_clk,
  output logic             shift_en
);

  localparam int CNT_W = DIV_W + (1 << EXP_W) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base_len;
  logic [CNT_W-1:0] half_m1;
  logic [EXP_W:0]   shamt;
  logic             slow, hold, bnd;
  logic             clk_q, sh_q;

  assign slow     = psave_en & ~bus_busy;
  assign shamt    = {1'b0, psave_exp} + {{EXP_W{1'b0}}, 1'b1};
  assign base_len = CNT_W'(div_sel) + CNT_W'(1);
  assign half_m1  = (slow ? (base_len << shamt) : base_len) - CNT_W'(1);
  assign hold     = bus_busy & ((rd_hold_en & xfer_read & fifo_full) |
                                (wr_hold_en & ~xfer_read & fifo_empty));
  assign bnd      = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt   <= '0;
      clk_q <= 1'b0;
      sh_q  <= 1'b0;
    end else begin
      sh_q <= 1'b0;
      if (bnd) begin
        cnt <= half_m1;
        if (clk_q) begin
          clk_q <= 1'b0;
          sh_q  <= 1'b1;
        end else if (!hold) begin
          clk_q <= 1'b1;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign card_clk = clk_q;
  assign shift_en = sh_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!card_clk && !shift_en)); // R1
  AST_RD_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && rd_hold_en && xfer_read && fifo_full && !card_clk) |=> !card_clk); // R4
  AST_WR_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && wr_hold_en && !xfer_read && fifo_empty && !card_clk) |=> !card_clk); // R5
  AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (!card_clk && $past(card_clk))); // R7
  AST_NO_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !card_clk) |=> !shift_en); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en); // R7

endmodule

// File: tb/cardclk_gen_tb.sv
module cardclk_gen_tb;
  logic clk = 0, rst_n = 0, enable = 0;
  logic [7:0] div_sel = 0;
  logic psave_en = 0;
  logic [2:0] psave_exp = 0;
  logic rd_hold_en = 0, wr_hold_en = 0, bus_busy = 0, xfer_read = 0;
  logic fifo_full = 0, fifo_empty = 0;
  logic card_clk, shift_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cardclk_gen u_dut (.clk, .rst_n, .enable, .div_sel, .psave_en, .psave_exp,
    .rd_hold_en, .wr_hold_en, .bus_busy, .xfer_read, .fifo_full, .fifo_empty,
    .card_clk, .shift_en);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(input string tag);
    bit prev = card_clk;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!prev && card_clk) return;
      prev = card_clk;
    end
    chk(0, {tag, " no rising edge"}, 0, 1);
  endtask

  task automatic measure(input int d, input string tag);
    int hi = 1, lo = 1, pulses;
    wait_rise(tag);
    wait_rise(tag);
    forever begin
      @(negedge clk);
      if (card_clk) hi++; else break;
    end
    chk(shift_en == 1'b1, {tag, " strobe at fall (R7)"}, shift_en, 1);
    pulses = shift_en;
    forever begin
      @(negedge clk);
      if (!card_clk) begin lo++; pulses += shift_en; end else break;
    end
    pulses += shift_en;
    chk(hi == d, {tag, " high length"}, hi, d);
    chk(lo == d, {tag, " low length"}, lo, d);
    chk(pulses == 1, {tag, " strobes per period (R7)"}, pulses, 1);
  endtask

  task automatic quiet_window(input int n, input string tag);
    int his = 0, strobes = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      his += card_clk;
      strobes += shift_en;
    end
    chk(his == 0, {tag, " clock stayed low"}, his, 0);
    chk(strobes == 0, {tag, " no strobe"}, strobes, 0);
  endtask

  task automatic t_reset;
    quiet_window(10, "R1 in reset");
    @(negedge clk) rst_n = 1;
    quiet_window(20, "R1 disabled");
  endtask

  task automatic t_divider;
    @(negedge clk) enable = 1; div_sel = 0;
    measure(1, "R2 div0");
    @(negedge clk) div_sel = 3;
    measure(4, "R2 div3");
    @(negedge clk) div_sel = 9;
    measure(10, "R2 div9");
  endtask

  task automatic t_psave;
    @(negedge clk) div_sel = 1; psave_en = 1; psave_exp = 0; bus_busy = 0;
    measure(4, "R3 exp0");
    @(negedge clk) psave_exp = 2;
    measure(16, "R3 exp2");
    @(negedge clk) div_sel = 0; psave_exp = 7;
    measure(256, "R3 exp7");
    @(negedge clk) div_sel = 1; bus_busy = 1;
    measure(2, "R3 busy no slowdown");
    @(negedge clk) psave_en = 0; bus_busy = 0;
    measure(2, "R3 psave off");
  endtask

  task automatic t_hold(input bit rd, input string tag);
    int hi, wait_lo;
    @(negedge clk) div_sel = 2; bus_busy = 1; xfer_read = rd;
    rd_hold_en = rd; wr_hold_en = !rd; fifo_full = 0; fifo_empty = 0;
    wait_rise(tag);
    if (rd) fifo_full = 1; else fifo_empty = 1;
    hi = 1;
    forever begin
      @(negedge clk);
      if (card_clk) hi++; else break;
    end
    chk(hi == 3, {tag, " R6 high not cut"}, hi, 3);
    quiet_window(40, tag);
    @(negedge clk) begin fifo_full = 0; fifo_empty = 0; end
    wait_lo = 0;
    while (!card_clk && wait_lo < 100) begin
      @(negedge clk);
      wait_lo++;
    end
    chk(wait_lo >= 1 && wait_lo <= 3, {tag, " R6 resume within level"}, wait_lo, 3);
    hi = 1;
    forever begin
      @(negedge clk);
      if (card_clk) hi++; else break;
    end
    chk(hi == 3, {tag, " R6 full high after resume"}, hi, 3);
  endtask

  task automatic t_cross_dir;
    @(negedge clk) rd_hold_en = 1; wr_hold_en = 1; bus_busy = 1;
    xfer_read = 1; fifo_full = 0; fifo_empty = 1;
    measure(3, "R5 empty ignored on read");
    @(negedge clk) xfer_read = 0; fifo_full = 1; fifo_empty = 0;
    measure(3, "R5 full ignored on write");
  endtask

  task automatic t_no_hold_enables;
    @(negedge clk) rd_hold_en = 0; wr_hold_en = 0; fifo_full = 1; fifo_empty = 1;
    xfer_read = 1;
    measure(3, "R8 read flags ignored");
    @(negedge clk) xfer_read = 0;
    measure(3, "R8 write flags ignored");
  endtask

  task automatic t_disable;
    wait_rise("R1 pre-disable");
    @(negedge clk) enable = 0;
    quiet_window(20, "R1 after disable");
  endtask

  initial begin
    t_reset();
    t_divider();
    t_psave();
    t_hold(1, "R4 read hold");
    t_hold(0, "R5 write hold");
    t_cross_dir();
    t_no_hold_enables();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule